// File: doc/BRIEF.md
# Repeat-Capable Data Transfer Channel

This block is a single transfer channel. Each accepted activation request moves one unit of data, either a byte or a 16-bit halfword, from a source address to a destination address. It does this through a simple memory master port that reads first and then writes. Software programs the channel through a small write port. It sets a 7-bit control word, a source start address, a destination start address and a block length in units.

In normal mode the channel counts down the block. It signals done once the last unit has been written. After that it refuses further activations until a new block length is written.

In repeat mode one side is chosen as the repeat area. That side steps forward on every unit and returns to its start address each time a block ends. The count reloads at the same point, and an optional end-of-block interrupt is raised. A chain request can follow every unit, unless the channel sits at the highest activation source number.

Top module: `xfer_chan`

## Requirements
- R1: After reset the control readback is 0x00, and mem_rd, mem_wr, done, rpt_irq and chain_req are all 0.
- R2: Control bits are: [0] mode (1 repeat), [1] repeat side (1 source, 0 destination), [2] source step enable, [3] destination step enable, [4] chain enable, [5] repeat interrupt enable, [6] size (1 = 16-bit). Bit 7 always reads 0, and writes to it are ignored. Register select codes are 0 control, 1 source, 2 destination, 3 length.
- R3: An activation accepted in idle produces a read of the source one cycle later and a write of the destination two cycles after that. The write data is the read data, with the upper byte cleared for byte units. Read data returns one cycle after mem_rd.
- R4: A side whose step bit is 0 keeps its address. A side whose step bit is 1 advances by 1 (byte) or 2 (halfword) after every unit.
- R5: In normal mode done pulses for one cycle, the cycle after the write of the last unit. Later activations cause no memory access until the length register is written again.
- R6: In repeat mode the repeat side advances after every unit regardless of its step bit. After N units it returns to its start address, the count reloads to N, and the channel keeps running.
- R7: In normal mode the repeat-side bit and the repeat interrupt enable have no effect on addresses or pulses.
- R8: rpt_irq pulses the cycle after the write that ends a repeat block, and only when the repeat interrupt enable is set. It never pulses in normal mode.
- R9: With chain enabled, chain_req pulses for one cycle after every unit write. A channel whose activation source number equals the highest number never raises chain_req.
- R10: Activation requests that arrive while a unit is in progress are dropped.
- R11: Writing a block length of 0 leaves the channel disarmed, and activations then cause no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 source, 2 destination, 3 length) |
| reg_wdata | input | ADDR_W | Register write data |
| ctrl_o | output | 8 | Control word readback |
| act | input | 1 | Activation request |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wide | output | 1 | Unit size (1 = 16-bit) |
| mem_addr | output | ADDR_W | Memory address |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| mem_wdata | output | 16 | Write data |
| done | output | 1 | End-of-block pulse, normal mode |
| rpt_irq | output | 1 | End-of-block interrupt pulse, repeat mode |
| chain_req | output | 1 | Chain request pulse after a unit |

## Verification
The hardest situation to reach from the ports is the block boundary in repeat mode. There the repeat side must snap back to its start address while the other side keeps following its own step bit, and the interrupt must fire or stay quiet according to the enable. The stimulus drives each repeat configuration for more units than one block holds, so that two or more wraps occur. A model in the bench predicts every read address, write address and pulse from the control bits alone. Several vectors set step bits that the mode makes irrelevant, which shows that those bits are ignored.

// File: rtl/xfer_chan.sv
module xfer_chan #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int ACT_ID     = 0,
  parameter int ACT_ID_MAX = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [7:0]        ctrl_o,
  input  logic              act,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       mem_wdata,
  output logic              done,
  output logic              rpt_irq,
  output logic              chain_req
);
  localparam logic CHAIN_OK = (ACT_ID != ACT_ID_MAX);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_LAT, S_WR} st_t;

  st_t              st;
  logic [6:0]       ctl;
  logic [ADDR_W-1:0] src, dst, src_base, dst_base;
  logic [CNT_W-1:0] cnt, len;
  logic             armed;
  logic [15:0]      data_q;

  wire rpt   = ctl[0];
  wire rsel  = ctl[1];
  wire s_inc = ctl[2];
  wire d_inc = ctl[3];
  wire chne  = ctl[4];
  wire rie   = ctl[5];
  wire wide  = ctl[6];

  wire src_rep = rpt & rsel;
  wire dst_rep = rpt & ~rsel;
  wire last    = (cnt == CNT_W'(1));
  wire accept  = (st == S_IDLE) && act && armed;

  wire [ADDR_W-1:0] step = {{(ADDR_W-2){1'b0}}, wide, ~wide};

  wire [ADDR_W-1:0] src_nx = (src_rep && last) ? src_base :
                             (src_rep || s_inc) ? src + step : src;
  wire [ADDR_W-1:0] dst_nx = (dst_rep && last) ? dst_base :
                             (dst_rep || d_inc) ? dst + step : dst;
  wire [CNT_W-1:0]  cnt_nx = last ? (rpt ? len : '0) : cnt - CNT_W'(1);

  assign ctrl_o    = {1'b0, ctl};
  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_wide  = wide;
  assign mem_addr  = (st == S_WR) ? dst : src;
  assign mem_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ctl       <= '0;
      src       <= '0;
      dst       <= '0;
      src_base  <= '0;
      dst_base  <= '0;
      cnt       <= '0;
      len       <= '0;
      armed     <= 1'b0;
      data_q    <= '0;
      done      <= 1'b0;
      rpt_irq   <= 1'b0;
      chain_req <= 1'b0;
    end else begin
      done      <= (st == S_WR) && last && !rpt;
      rpt_irq   <= (st == S_WR) && last && rpt && rie;
      chain_req <= (st == S_WR) && chne && CHAIN_OK;
      case (st)
        S_IDLE: if (accept) st <= S_RD;
        S_RD:   st <= S_LAT;
        S_LAT: begin
          data_q <= wide ? mem_rdata : {8'h00, mem_rdata[7:0]};
          st     <= S_WR;
        end
        S_WR: begin
          src <= src_nx;
          dst <= dst_nx;
          cnt <= cnt_nx;
          if (last && !rpt) armed <= 1'b0;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (reg_we) begin
        case (reg_sel)
          2'd0: ctl <= reg_wdata[6:0];
          2'd1: begin src <= reg_wdata; src_base <= reg_wdata; end
          2'd2: begin dst <= reg_wdata; dst_base <= reg_wdata; end
          default: begin
            len   <= reg_wdata[CNT_W-1:0];
            cnt   <= reg_wdata[CNT_W-1:0];
            armed <= |reg_wdata[CNT_W-1:0];
          end
        endcase
      end
    end
  end

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));

  // R3
  no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R5
  done_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_wr && !rpt));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_irq |-> $past(mem_wr && rpt && rie));

  // R9
  chain_after_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_req |-> $past(mem_wr && chne));

  // R5
  single_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && rpt_irq));
endmodule

// File: tb/test_xfer_chan.sv
module test_xfer_chan;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        act = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [7:0]  ctrl_o, ctrl_o_l;
  logic        mem_rd, mem_wr, mem_wide, done, rpt_irq, chain_req;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_rd_l, mem_wr_l, mem_wide_l, done_l, rpt_irq_l, chain_last;
  logic [15:0] mem_addr_l, mem_wdata_l;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_chan i_xfer_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_o(ctrl_o), .act(act), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .done(done),
    .rpt_irq(rpt_irq), .chain_req(chain_req));

  xfer_chan #(.ACT_ID(7), .ACT_ID_MAX(7)) i_xfer_chan_last (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_o(ctrl_o_l), .act(act), .mem_rd(mem_rd_l),
    .mem_wr(mem_wr_l), .mem_wide(mem_wide_l), .mem_addr(mem_addr_l),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata_l), .done(done_l),
    .rpt_irq(rpt_irq_l), .chain_req(chain_last));

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_addr ^ 16'hA5C3;

  // control, src, dst, len, units
  localparam logic [55:0] VEC [6] = '{
    {8'h0C, 16'h1000, 16'h2000, 8'd4, 8'd5},
    {8'h44, 16'h1100, 16'h2200, 8'd3, 8'd3},
    {8'h21, 16'h1200, 16'h2300, 8'd3, 8'd7},
    {8'h47, 16'h1300, 16'h2400, 8'd2, 8'd5},
    {8'h7B, 16'h1400, 16'h2500, 8'd2, 8'd5},
    {8'h3E, 16'h1500, 16'h2600, 8'd2, 8'd3}
  };

  logic [7:0]  m_ctl;
  logic [15:0] m_src, m_dst, m_src0, m_dst0;
  int          m_cnt, m_len;
  bit          m_armed;
  bit          e_done, e_irq, e_chain;

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel == 2'd0) m_ctl = {1'b0, d[6:0]};
    if (sel == 2'd1) begin m_src = d; m_src0 = d; end
    if (sel == 2'd2) begin m_dst = d; m_dst0 = d; end
    if (sel == 2'd3) begin m_len = d[7:0]; m_cnt = d[7:0]; m_armed = (d[7:0] != 0); end
  endtask

  task automatic model_step();
    logic [15:0] stp;
    bit rpt, srep, drep;
    stp  = m_ctl[6] ? 16'd2 : 16'd1;
    rpt  = m_ctl[0];
    srep = rpt & m_ctl[1];
    drep = rpt & ~m_ctl[1];
    if (srep || m_ctl[2]) m_src = m_src + stp;
    if (drep || m_ctl[3]) m_dst = m_dst + stp;
    m_cnt--;
    e_done = 0; e_irq = 0;
    e_chain = m_ctl[4];
    if (m_cnt == 0) begin
      if (rpt) begin
        if (srep) m_src = m_src0;
        if (drep) m_dst = m_dst0;
        m_cnt = m_len;
        e_irq = m_ctl[5];
      end else begin
        m_armed = 0;
        e_done = 1;
      end
    end
  endtask

  task automatic run_unit();
    logic [15:0] ew;
    @(negedge clk) act = 1'b1;
    @(negedge clk) act = 1'b0;
    if (!m_armed) begin
      check(mem_rd == 1'b0, "R5/R11 no read when disarmed", mem_rd, 0);
      repeat (3) begin
        @(negedge clk);
        check(!mem_rd && !mem_wr && !done, "R5/R11 idle when disarmed",
              {mem_rd, mem_wr, done}, 0);
      end
      return;
    end
    check(mem_rd && mem_addr == m_src, "R3/R4/R6 read address", mem_addr, m_src);
    @(negedge clk);
    @(negedge clk);
    ew = m_src ^ 16'hA5C3;
    if (!m_ctl[6]) ew[15:8] = 8'h00;
    check(mem_wr && mem_addr == m_dst, "R3/R4/R6 write address", mem_addr, m_dst);
    check(mem_wdata == ew, "R3 write data", mem_wdata, ew);
    check(mem_wide == m_ctl[6], "R2 size", mem_wide, m_ctl[6]);
    model_step();
    @(negedge clk);
    check(done == e_done, "R5/R7 done pulse", done, e_done);
    check(rpt_irq == e_irq, "R8/R7 rpt_irq pulse", rpt_irq, e_irq);
    check(chain_req == e_chain, "R9 chain_req", chain_req, e_chain);
    check(chain_last == 1'b0, "R9 chain suppressed at top id", chain_last, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int rd_seen;
    m_ctl = 0; m_src = 0; m_dst = 0; m_src0 = 0; m_dst0 = 0;
    m_cnt = 0; m_len = 0; m_armed = 0;
    repeat (3) @(negedge clk);
    // R1
    check(ctrl_o == 8'h00, "R1 control reset", ctrl_o, 0);
    check(!mem_rd && !mem_wr && !done && !rpt_irq && !chain_req,
          "R1 outputs idle", {mem_rd, mem_wr, done, rpt_irq, chain_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: not armed out of reset
    run_unit();

    for (int v = 0; v < 6; v++) begin
      wr_reg(2'd0, {8'h00, VEC[v][55:48]});
      wr_reg(2'd1, VEC[v][47:32]);
      wr_reg(2'd2, VEC[v][31:16]);
      wr_reg(2'd3, {8'h00, VEC[v][15:8]});
      for (int u = 0; u < int'(VEC[v][7:0]); u++) run_unit();
    end

    // R2: bit 7 write ignored, layout readback
    wr_reg(2'd0, 16'h00FF);
    check(ctrl_o == 8'h7F, "R2 bit7 reads 0", ctrl_o, 8'h7F);
    wr_reg(2'd0, 16'h00A5);
    check(ctrl_o == 8'h25, "R2 control readback", ctrl_o, 8'h25);

    // R5: re-arm after done by rewriting length
    wr_reg(2'd0, 16'h000C);
    wr_reg(2'd1, 16'h3000);
    wr_reg(2'd2, 16'h4000);
    wr_reg(2'd3, 16'h0001);
    run_unit();
    run_unit();
    wr_reg(2'd3, 16'h0002);
    run_unit();

    // R11: zero length disarms
    wr_reg(2'd3, 16'h0000);
    run_unit();

    // R10: activation held high across a unit is taken once
    wr_reg(2'd0, 16'h0004);
    wr_reg(2'd1, 16'h3100);
    wr_reg(2'd2, 16'h4100);
    wr_reg(2'd3, 16'h0005);
    rd_seen = 0;
    @(negedge clk) act = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (mem_rd) rd_seen++;
    end
    act = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (mem_rd) rd_seen++;
    end
    check(rd_seen == 1, "R10 busy activations dropped", rd_seen, 1);
    model_step();
    run_unit();

    finish_run();
  end
endmodule